// File: doc/BRIEF.md
# Dual Reference Frequency Window Monitor

This block checks two reference clock inputs at the same time. Each input is compared with its own nominal rate. A trusted system clock times a long measurement gate, 2 seconds by default. During the gate, each channel counts the rising edges of its reference after the reference has been brought into the system clock domain. When the gate closes, each channel compares its count with a lower and an upper limit. The limits are worked out when the design is elaborated, from the nominal rate, the gate length and a tolerance of ±12 ppm. A registered per-channel flag then reports whether that reference is off frequency. The flag keeps its value until the next gate closes.

Each channel has a 2-bit rate code that selects one of four telecom nominal rates. The two channels may use the same rate code or different ones. The system clock frequency, the gate length, the tolerance and the four nominal rates are all parameters. This lets a scaled-down configuration exercise the same comparison logic within a short run. A reference that is lost completely gives a zero count, and a zero count always raises the flag.

Top module: `refmon_dual`

## Requirements
- R1: A channel whose gate count is below its lower limit LO = ceil(NOM·GATE_CYCLES·(10^6−TOL_PPM) / (SYS_HZ·10^6)) raises its flag after that gate closes.
- R2: A channel whose gate count is above its upper limit HI = floor(NOM·GATE_CYCLES·(10^6+TOL_PPM) / (SYS_HZ·10^6)) raises its flag after that gate closes.
- R3: A channel whose gate count lies in the inclusive range LO..HI, and is not zero, clears its flag after that gate closes.
- R4: The rate code selects NOM as follows: 2'b00 = NOM0_HZ (8 kHz), 2'b01 = NOM1_HZ (1.544 MHz), 2'b10 = NOM2_HZ (2.048 MHz), 2'b11 = NOM3_HZ (19.44 MHz). TOL_PPM defaults to 12. The code is sampled in the cycle in which the gate closes.
- R5: The two channels are independent. Each uses only its own reference, its own rate code and its own count.
- R6: Gates are GATE_CYCLES system clocks long and follow each other without a gap, starting at reset release. A flag changes only on the clock edge that closes a gate, so it holds one value throughout the following gate.
- R7: A gate in which a reference shows no rising edge sets that channel's flag, whatever the limits are.
- R8: Both flags are 0 during reset and stay 0 until the first gate after reset has closed.
- R9: The edge counter is CNT_W bits wide, 26 by default. It stops at 2^CNT_W−1 instead of wrapping around.
- R10: Each reference passes through a two-flop synchronizer. One count is added for each rising edge of the synchronized signal. A reference that is high for one system clock and low for one system clock is counted on every rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, trusted local timebase |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_a_i | input | 1 | Reference A, asynchronous to clk |
| ref_b_i | input | 1 | Reference B, asynchronous to clk |
| rate_a_i | input | 2 | Nominal rate code for reference A |
| rate_b_i | input | 2 | Nominal rate code for reference B |
| off_a_o | output | 1 | Reference A off frequency (registered) |
| off_b_o | output | 1 | Reference B off frequency (registered) |

## Verification
The bench builds the monitor with SYS_HZ = 1 000 000, GATE_CYCLES = 2000, TOL_PPM = 100 000 and nominal rates of 20, 40, 100 and 250 kHz. With these values the expected counts are 40, 80, 200 and 500, and the limit windows are a few counts wide. This puts LO−1, LO, the nominal count, HI, HI+1 and zero within reach of single gates, for every rate code on both channels at once. Each channel is driven with a different rate code and a different count, which tests R5. A second instance uses a 6-bit counter. In it, 104 edges give a flagged result only if the counter stops at its maximum: a counter that wrapped would land inside the window.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

    localparam int unsigned NUM_RATES = 4;
    localparam longint unsigned PPM_SCALE = 64'd1_000_000;

    typedef logic [1:0] rate_code_t;

    // Smallest count still inside the window (rounded up)
    function automatic logic [63:0] window_low(
        input longint unsigned nom_hz,
        input longint unsigned gate_cyc,
        input longint unsigned sys_hz,
        input longint unsigned tol_ppm
    );
        logic [127:0] num;
        logic [127:0] den;
        num = 128'(nom_hz) * 128'(gate_cyc) * 128'(PPM_SCALE - tol_ppm);
        den = 128'(sys_hz) * 128'(PPM_SCALE);
        return 64'((num + den - 128'd1) / den);
    endfunction

    // Largest count still inside the window (rounded down)
    function automatic logic [63:0] window_high(
        input longint unsigned nom_hz,
        input longint unsigned gate_cyc,
        input longint unsigned sys_hz,
        input longint unsigned tol_ppm
    );
        logic [127:0] num;
        logic [127:0] den;
        num = 128'(nom_hz) * 128'(gate_cyc) * 128'(PPM_SCALE + tol_ppm);
        den = 128'(sys_hz) * 128'(PPM_SCALE);
        return 64'(num / den);
    endfunction

endpackage

// File: rtl/refmon_edge_sync.sv
module refmon_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic rise_o
);
    // pipe[0], pipe[1]: synchronizer; pipe[2]: previous synchronized level
    typedef struct packed {
        logic [2:0] pipe;
    } sync_t;

    sync_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[1:0], ref_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.pipe[1] & ~st_q.pipe[2];

    // R10: a reported edge cannot repeat on the next cycle
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/refmon_gate_timer.sv
module refmon_gate_timer #(
    parameter longint unsigned GATE_CYCLES = 64'd200_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic gate_end_o
);
    localparam int TW = (GATE_CYCLES > 1) ? $clog2(GATE_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(GATE_CYCLES - 1);

    typedef struct packed {
        logic [TW-1:0] tick;
    } tmr_t;

    tmr_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.tick == LAST) st_d.tick = '0;
        else                   st_d.tick = st_q.tick + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate_end_o = (st_q.tick == LAST);

    // R6: gate boundary returns the timer to zero
    a_r6_gate_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        gate_end_o |=> (st_q.tick == '0));

    // R6: inside a gate the timer advances by exactly one
    a_r6_gate_step: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_end_o |=> (st_q.tick == $past(st_q.tick) + TW'(1)));

endmodule

// File: rtl/refmon_chan.sv
module refmon_chan
    import refmon_pkg::*;
#(
    parameter int              CNT_W       = 26,
    parameter longint unsigned SYS_HZ      = 64'd100_000_000,
    parameter longint unsigned GATE_CYCLES = 64'd200_000_000,
    parameter longint unsigned TOL_PPM     = 64'd12,
    parameter longint unsigned NOM0_HZ     = 64'd8_000,
    parameter longint unsigned NOM1_HZ     = 64'd1_544_000,
    parameter longint unsigned NOM2_HZ     = 64'd2_048_000,
    parameter longint unsigned NOM3_HZ     = 64'd19_440_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise_i,
    input  logic       gate_end_i,
    input  rate_code_t rate_i,
    output logic       off_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             off;
    } chan_t;

    chan_t st_q, st_d;

    logic [CNT_W-1:0] low_tab  [NUM_RATES];
    logic [CNT_W-1:0] high_tab [NUM_RATES];

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_limits
        localparam longint unsigned NOM = (g == 0) ? NOM0_HZ :
                                          (g == 1) ? NOM1_HZ :
                                          (g == 2) ? NOM2_HZ : NOM3_HZ;
        localparam logic [63:0] LOW_FULL  = window_low(NOM, GATE_CYCLES, SYS_HZ, TOL_PPM);
        localparam logic [63:0] HIGH_FULL = window_high(NOM, GATE_CYCLES, SYS_HZ, TOL_PPM);
        assign low_tab[g]  = LOW_FULL[CNT_W-1:0];
        assign high_tab[g] = HIGH_FULL[CNT_W-1:0];
    end

    logic [CNT_W-1:0] total;
    logic [CNT_W-1:0] low_sel;
    logic [CNT_W-1:0] high_sel;

    always_comb begin
        low_sel  = low_tab[rate_i];
        high_sel = high_tab[rate_i];
        total    = (st_q.cnt == CNT_MAX) ? CNT_MAX : st_q.cnt + CNT_W'(rise_i);

        st_d = st_q;
        if (gate_end_i) begin
            st_d.cnt = '0;
            st_d.off = (total == '0) || (total < low_sel) || (total > high_sel);
        end else begin
            st_d.cnt = total;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign off_o = st_q.off;

    // R6: flag can only move on a gate boundary
    a_r6_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_end_i |=> $stable(off_o));

    // R6: a new gate starts from an empty count
    a_r6_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
        gate_end_i |=> (st_q.cnt == '0));

    // R7: no edge in the whole gate always flags
    a_r7_zero_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_end_i && st_q.cnt == '0 && !rise_i) |=> off_o);

    // R9: a full counter stays full until the gate closes
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_MAX && !gate_end_i) |=> (st_q.cnt == CNT_MAX));

    // R10: at most one count per cycle
    a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_end_i && st_q.cnt != CNT_MAX) |=> (st_q.cnt - $past(st_q.cnt) <= CNT_W'(1)));

endmodule

// File: rtl/refmon_dual.sv
module refmon_dual
    import refmon_pkg::*;
#(
    parameter int              CNT_W       = 26,
    parameter longint unsigned SYS_HZ      = 64'd100_000_000,
    parameter longint unsigned GATE_CYCLES = 64'd200_000_000,
    parameter longint unsigned TOL_PPM     = 64'd12,
    parameter longint unsigned NOM0_HZ     = 64'd8_000,
    parameter longint unsigned NOM1_HZ     = 64'd1_544_000,
    parameter longint unsigned NOM2_HZ     = 64'd2_048_000,
    parameter longint unsigned NOM3_HZ     = 64'd19_440_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_a_i,
    input  logic       ref_b_i,
    input  logic [1:0] rate_a_i,
    input  logic [1:0] rate_b_i,
    output logic       off_a_o,
    output logic       off_b_o
);
    localparam int NUM_CH = 2;

    logic       ref_v  [NUM_CH];
    rate_code_t rate_v [NUM_CH];
    logic       rise_v [NUM_CH];
    logic       off_v  [NUM_CH];
    logic       gate_end;

    assign ref_v[0]  = ref_a_i;
    assign ref_v[1]  = ref_b_i;
    assign rate_v[0] = rate_a_i;
    assign rate_v[1] = rate_b_i;

    refmon_gate_timer #(
        .GATE_CYCLES(GATE_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_end_o(gate_end)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        refmon_edge_sync u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .ref_i (ref_v[c]),
            .rise_o(rise_v[c])
        );

        refmon_chan #(
            .CNT_W      (CNT_W),
            .SYS_HZ     (SYS_HZ),
            .GATE_CYCLES(GATE_CYCLES),
            .TOL_PPM    (TOL_PPM),
            .NOM0_HZ    (NOM0_HZ),
            .NOM1_HZ    (NOM1_HZ),
            .NOM2_HZ    (NOM2_HZ),
            .NOM3_HZ    (NOM3_HZ)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .rise_i    (rise_v[c]),
            .gate_end_i(gate_end),
            .rate_i    (rate_v[c]),
            .off_o     (off_v[c])
        );
    end

    assign off_a_o = off_v[0];
    assign off_b_o = off_v[1];

    // R8: flags are clear while reset is held
    always_comb begin
        if (!rst_n) begin
            a_r8_reset_clear: assert (!off_a_o && !off_b_o);
        end
    end

endmodule

// File: tb/refmon_dual_test.sv
module refmon_dual_test;

    localparam longint unsigned SYS  = 64'd1_000_000;
    localparam longint unsigned G    = 64'd2000;
    localparam longint unsigned TOL  = 64'd100_000;
    localparam longint unsigned N0   = 64'd20_000;
    localparam longint unsigned N1   = 64'd40_000;
    localparam longint unsigned N2   = 64'd100_000;
    localparam longint unsigned N3   = 64'd250_000;
    localparam longint unsigned MEGA = 64'd1_000_000;
    localparam int EDGE_START = 450;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ref_a, ref_b;
    logic [1:0] rate_a, rate_b;
    logic       off_a, off_b;
    logic       sat_off, sat_off_b;
    logic       zero_ref = 1'b0;
    logic [1:0] zero_rate = 2'b00;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    refmon_dual #(
        .CNT_W(10), .SYS_HZ(SYS), .GATE_CYCLES(G), .TOL_PPM(TOL),
        .NOM0_HZ(N0), .NOM1_HZ(N1), .NOM2_HZ(N2), .NOM3_HZ(N3)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ref_a_i(ref_a), .ref_b_i(ref_b),
        .rate_a_i(rate_a), .rate_b_i(rate_b), .off_a_o(off_a), .off_b_o(off_b)
    );

    refmon_dual #(
        .CNT_W(6), .SYS_HZ(SYS), .GATE_CYCLES(G), .TOL_PPM(TOL),
        .NOM0_HZ(N0), .NOM1_HZ(N1), .NOM2_HZ(N2), .NOM3_HZ(N3)
    ) sat_uut (
        .clk(clk), .rst_n(rst_n), .ref_a_i(ref_a), .ref_b_i(zero_ref),
        .rate_a_i(zero_rate), .rate_b_i(zero_rate), .off_a_o(sat_off), .off_b_o(sat_off_b)
    );

    function automatic longint unsigned nom_of(input int s);
        case (s)
            0:       return N0;
            1:       return N1;
            2:       return N2;
            default: return N3;
        endcase
    endfunction

    function automatic int lo_of(input int s);
        longint unsigned den = SYS * MEGA;
        return int'((nom_of(s) * G * (MEGA - TOL) + den - 1) / den);
    endfunction

    function automatic int hi_of(input int s);
        return int'((nom_of(s) * G * (MEGA + TOL)) / (SYS * MEGA));
    endfunction

    function automatic int pick(input int s, input int k);
        case (k)
            0:       return lo_of(s) - 1;
            1:       return lo_of(s);
            2:       return int'(nom_of(s) * G / SYS);
            3:       return hi_of(s);
            4:       return hi_of(s) + 1;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(input int k);
        case (k)
            0:       return "R1";
            4:       return "R2";
            5:       return "R7";
            default: return "R3";
        endcase
    endfunction

    function automatic logic flag_of(input int s, input int n);
        return (n == 0) || (n < lo_of(s)) || (n > hi_of(s));
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // expectations carried from one gate to the next
    bit    have_prev = 0;
    logic  ex_a, ex_b;
    string tg_a, tg_b;
    bit    have_sat = 0;
    logic  ex_sat;

    task automatic one_gate(input bit first, input int sa, input int sb,
                            input int na, input int nb, input string ta,
                            input string tb, input bit sat_gate);
        logic s_a, s_b;
        s_a = 1'b0;
        s_b = 1'b0;
        for (int o = 0; o < int'(G); o++) begin
            @(negedge clk);
            if (o == 100) begin
                s_a = off_a;
                s_b = off_b;
                if (first) begin
                    check("R8", "flag A before first gate closed", off_a, 1'b0);
                    check("R8", "flag B before first gate closed", off_b, 1'b0);
                end
                if (have_prev) begin
                    check(tg_a, "channel A result (R4 rate code)", off_a, ex_a);
                    check(tg_b, "channel B result (R5 independent)", off_b, ex_b);
                end
                if (have_sat) begin
                    check("R9", "6-bit counter saturates, not wraps", sat_off, ex_sat);
                    have_sat = 0;
                end
                rate_a = 2'(sa);
                rate_b = 2'(sb);
            end
            if (o == 1900) begin
                check("R6", "flag A held through gate", off_a, s_a);
                check("R6", "flag B held through gate", off_b, s_b);
            end
            ref_a = (o >= EDGE_START) && (o < EDGE_START + 2 * na) && ((o - EDGE_START) % 2 == 0);
            ref_b = (o >= EDGE_START) && (o < EDGE_START + 2 * nb) && ((o - EDGE_START) % 2 == 0);
        end
        have_prev = 1;
        ex_a = flag_of(sa, na);
        ex_b = flag_of(sb, nb);
        tg_a = ta;
        tg_b = tb;
        if (sat_gate) begin
            have_sat = 1;
            ex_sat   = 1'b1;
        end
    endtask

    initial begin
        #(150_000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n  = 1'b0;
        ref_a  = 1'b0;
        ref_b  = 1'b0;
        rate_a = 2'b00;
        rate_b = 2'b00;
        repeat (5) @(negedge clk);
        check("R8", "flag A in reset", off_a, 1'b0);
        check("R8", "flag B in reset", off_b, 1'b0);
        rst_n = 1'b1;

        // first gate: no edges at all -> R7 on both channels
        one_gate(1'b1, 0, 0, 0, 0, "R7", "R7", 1'b0);

        // sweep every rate code over the window edges, channels crossed (R4, R5)
        for (int v = 0; v < 24; v++) begin
            int s, k, kb;
            s  = v / 6;
            k  = v % 6;
            kb = (k + 3) % 6;
            one_gate(1'b0, s, 3 - s, pick(s, k), pick(3 - s, kb),
                     tag_of(k), tag_of(kb), 1'b0);
        end

        // R9: 104 edges -> full-width instance flags high (R2), 6-bit instance saturates at 63
        one_gate(1'b0, 0, 1, 104, pick(1, 2), "R2", "R3", 1'b1);

        // R10: one-cycle-high, one-cycle-low reference counted exactly at HI
        one_gate(1'b0, 3, 0, pick(3, 3), pick(0, 0), "R10", "R1", 1'b0);

        // collect the last result
        one_gate(1'b0, 0, 0, 0, 0, "R7", "R7", 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule